// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources and decides which one, if any, the processor should take. Each source has a pending flag that is set by a rising edge on its request line, and a three-bit priority field. A single global enable and a processor priority threshold apply to all sources. A source can be taken only when the enable is on, its pending flag is set, and its priority is strictly above the threshold.

Among the sources that can be taken, the one with the highest priority wins. When two or more share that priority, the lowest source index wins. The block shows the winner on `irq_valid` and `irq_idx`. When the processor pulses `irq_ack`, the winner's pending flag is cleared. Software reaches the block through a small write port. It can set each priority, set the threshold, switch the global enable, and clear pending flags. It can never set a pending flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every pending flag, every priority field, the global enable and the threshold are 0, and `irq_valid` is 0.
- R2: A 0-to-1 transition on `req_i[i]` sets pending flag i. A request held high sets the flag only once, so it does not set it again after the flag is cleared.
- R3: Writing address 2 clears pending flag i where `wr_data[i]` is 0. A 1 in `wr_data[i]` leaves flag i unchanged and never sets it.
- R4: When the global enable (address 0, bit 0) is 0, `irq_valid` is 0 whatever the pending flags and priorities are.
- R5: A source can be taken only if its priority is strictly greater than the threshold (address 1, bits 2:0). A source with priority 0 is never taken, and a threshold of 7 blocks every source.
- R6: Among the sources that can be taken, `irq_idx` names the one with the highest priority. Ties go to the lowest index.
- R7: When `irq_ack` is 1 while `irq_valid` is 1, the clock edge clears the pending flag of the source named by `irq_idx`. The output then moves to the next winner, or `irq_valid` drops to 0 if there is none.
- R8: A request rising edge on a source wins over a software clear or an acknowledge of that same source in the same cycle, so the flag stays set.
- R9: The enable, the threshold, the pending flags and the priority of source i (written at address 3+i, bits 2:0) are separate storage. A write to one of them never changes any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request lines, one per source, edge-detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: 0 enable, 1 threshold, 2 pending clear, 3+i priority of source i |
| wr_data | input | DW | Write data |
| irq_ack | input | 1 | Processor acknowledge of the current winner |
| irq_valid | output | 1 | A source is eligible to be taken |
| irq_idx | output | IW | Index of the winning source |

## Verification
The hardest cases to reach from the ports are the collisions on a single pending flag. In one, a request edge lands in the same cycle as a software clear. In the other, it lands in the same cycle as an acknowledge of that same source. The bench builds both by hand. It drives the rising edge, the write strobe and the acknowledge at the same falling clock edge. After the next rising edge, it checks that the source is still the winner. Arbitration is covered by a sweep over every combination of four-source priorities, with the threshold varied across the sweep.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 8,
  parameter int LW = 3,
  localparam int AW = $clog2(N + 3),
  localparam int DW = (N > LW) ? N : LW,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_ack,
  output logic          irq_valid,
  output logic [IW-1:0] irq_idx
);

  logic                  en_q;
  logic [LW-1:0]         ipl_q;
  logic [N-1:0]          pend_q;
  logic [N-1:0]          req_q;
  logic [N-1:0][LW-1:0]  lvl_q;

  wire [N-1:0] rise    = req_i & ~req_q;
  wire [N-1:0] sw_clr  = (wr_en && wr_addr == AW'(2)) ? ~wr_data[N-1:0] : '0;
  wire [N-1:0] ack_clr = (irq_ack && irq_valid) ? (N'(1) << irq_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ipl_q  <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~sw_clr & ~ack_clr) | rise;
      if (wr_en && wr_addr == AW'(0)) en_q  <= wr_data[0];
      if (wr_en && wr_addr == AW'(1)) ipl_q <= wr_data[LW-1:0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(3 + i))
        lvl_q[i] <= wr_data[LW-1:0];
    end
  end

  logic          found;
  logic [LW-1:0] best_lvl;
  logic [IW-1:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (en_q && pend_q[i] && lvl_q[i] > ipl_q && (!found || lvl_q[i] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_q[i];
        best_idx = IW'(i);
      end
    end
  end

  assign irq_valid = found;
  assign irq_idx   = best_idx;

endmodule

module prio_irq_ctrl_chk #(
  parameter int N  = 8,
  parameter int LW = 3,
  parameter int IW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_q,
  input logic [LW-1:0]   ipl_q,
  input logic [N-1:0]    pend_q,
  input logic [N*LW-1:0] lvl_flat,
  input logic [N-1:0]    req_i,
  input logic [N-1:0]    req_q,
  input logic            irq_valid,
  input logic [IW-1:0]   irq_idx,
  input logic            irq_ack
);

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_valid);

  // R5
  ipl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_q == '1 |-> !irq_valid);

  // R5
  win_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend_q[irq_idx] && lvl_flat[irq_idx*LW +: LW] > ipl_q));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !(req_i[irq_idx] && !req_q[irq_idx])) |=> !pend_q[$past(irq_idx)]);

  for (genvar i = 0; i < N; i++) begin : g_src
    // R3
    set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(req_i[i] && !req_q[i]));
    // R8
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[i] && !req_q[i]) |=> pend_q[i]);
  end

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N), .LW(LW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .ipl_q(ipl_q), .pend_q(pend_q),
  .lvl_flat(lvl_q), .req_i(req_i), .req_q(req_q), .irq_valid(irq_valid),
  .irq_idx(irq_idx), .irq_ack(irq_ack)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = $clog2(N + 3);
  localparam int DW = (N > 3) ? N : 3;
  localparam int IW = $clog2(N);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  req_i = '0;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          irq_ack = 0;
  logic          irq_valid;
  logic [IW-1:0] irq_idx;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.N(N), .LW(3)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    req_i = req_i | m;
    tick();
    req_i = req_i & ~m;
    tick();
  endtask

  task automatic ack();
    irq_ack = 1;
    tick();
    irq_ack = 0;
  endtask

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 valid after reset", irq_valid, 0);
    wr(0, 1);
    pulse('1);
    chk("R1 levels reset to 0", irq_valid, 0);
    wr(2, 0);

    // R5 single-source sweep of level against threshold
    for (int t = 0; t < 8; t++) begin
      for (int lv = 0; lv < 8; lv++) begin
        wr(3, lv);
        wr(1, t);
        pulse(4'b0001);
        chk("R5 strict greater", irq_valid, (lv > t) ? 1 : 0);
        if (lv > t) chk("R5 index", irq_idx, 0);
        wr(2, 0);
        chk("R3 clear", irq_valid, 0);
      end
    end

    // R4 global enable gate, R9 pending retained across enable writes
    wr(1, 0);
    wr(3, 7);
    pulse(4'b0001);
    wr(0, 0);
    chk("R4 enable off", irq_valid, 0);
    wr(0, 1);
    chk("R9 pending kept over enable write", irq_valid, 1);

    // R3 ones do not set, zero clears
    wr(2, 4'hF);
    chk("R3 ones keep flag", irq_valid, 1);
    wr(2, 4'b1110);
    chk("R3 zero clears", irq_valid, 0);
    wr(2, 4'hF);
    chk("R3 ones never set", irq_valid, 0);

    // R9 independence
    wr(3, 6);
    pulse(4'b0001);
    wr(1, 2);
    wr(5, 1);
    wr(0, 1);
    wr(2, 4'hF);
    chk("R9 valid after other writes", irq_valid, 1);
    chk("R9 idx after other writes", irq_idx, 0);
    wr(1, 6);
    chk("R9 level kept, ipl 6 blocks 6", irq_valid, 0);
    wr(1, 7);
    wr(3, 7);
    chk("R5 ipl 7 blocks level 7", irq_valid, 0);
    wr(1, 0);
    wr(2, 0);
    wr(5, 0);

    // R7 acknowledge sequence
    wr(3, 3);
    wr(4, 5);
    pulse(4'b0011);
    chk("R6 higher wins idx", irq_idx, 1);
    ack();
    chk("R7 next winner valid", irq_valid, 1);
    chk("R7 next winner idx", irq_idx, 0);
    ack();
    chk("R7 all cleared", irq_valid, 0);

    // R2 held request sets once
    req_i[0] = 1;
    tick();
    chk("R2 edge sets", irq_valid, 1);
    ack();
    repeat (3) tick();
    chk("R2 held level no reset", irq_valid, 0);
    req_i[0] = 0;
    tick();
    req_i[0] = 1;
    tick();
    chk("R2 new edge sets", irq_valid, 1);
    req_i[0] = 0;
    wr(2, 0);

    // R8 collisions
    req_i[1] = 1;
    wr_en = 1; wr_addr = AW'(2); wr_data = DW'(4'b1101);
    tick();
    wr_en = 0;
    req_i[1] = 0;
    chk("R8 set beats sw clear", irq_valid, 1);
    chk("R8 idx", irq_idx, 1);
    tick();
    req_i[1] = 1; irq_ack = 1;
    tick();
    req_i[1] = 0; irq_ack = 0;
    chk("R8 set beats ack", irq_valid, 1);
    chk("R8 ack idx", irq_idx, 1);
    wr(2, 0);

    // R6 exhaustive level sweep with varying threshold
    pulse('1);
    for (int c = 0; c < 4096; c++) begin
      int l0, l1, l2, l3, t, best, bi;
      int lv[4];
      l0 = c & 7; l1 = (c >> 3) & 7; l2 = (c >> 6) & 7; l3 = (c >> 9) & 7;
      t = c % 5;
      lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3;
      wr(3, l0); wr(4, l1); wr(5, l2); wr(6, l3); wr(1, t);
      best = 0; bi = 0;
      for (int i = 0; i < 4; i++)
        if (lv[i] > t && lv[i] > best) begin best = lv[i]; bi = i; end
      chk("R6 valid", irq_valid, (best > 0) ? 1 : 0);
      if (best > 0) chk("R6 winner", irq_idx, bi);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule